// File: doc/BRIEF.md
# Transmit Descriptor Engine with Address-Table Load

The block walks a ring of transmit descriptors in memory and feeds the bytes of each buffer to a MAC as a byte stream. Software lays out the descriptors, sets the ring base and the transmit-enable mode bit, and then writes the poll register. The engine reads the status word of the current descriptor. If the ownership bit is set, it reads the control word and the buffer pointer, moves the buffer out, writes the status word back with ownership cleared, and goes on to the next descriptor. It stops on the first descriptor it does not own.

A descriptor whose control word carries the setup flag is not sent. Its 192-byte buffer is loaded into a 16-entry table of exact-match destination addresses. A lookup port reports whether a 48-bit destination address hits any entry. A pass-all-multicast mode bit also accepts any group address.

Each descriptor is four 32-bit words, 16 bytes apart. The status word is at +0, the control word at +4 and the buffer address at +8. The word at +12 is not used.

Top module: `tx_desc_engine`

## Requirements
- R1: Register writes use address 0 for the ring base, 1 for poll and 2 for mode. Mode bit 13 enables transmission. A poll write while bit 13 is clear starts no memory access. After reset nothing is streamed and no memory request is made.
- R2: If the status word read on a poll has bit 31 (ownership) clear, the engine makes no further access, writes nothing, streams nothing and returns to idle.
- R3: For an owned descriptor the engine reads status (+0), then control (+4), then buffer address (+8), then the buffer word by word. A 7-byte buffer costs two buffer reads.
- R4: Buffer bytes leave in ascending address order, least significant byte of each word first, one per valid/ready handshake. Data and valid hold while ready is low.
- R5: Control bit 29 (first segment) marks the first byte of the buffer with tx_first_o. Control bit 30 (last segment) marks its final byte with tx_last_o. The byte count is in control bits [10:0].
- R6: On completion the status word is written back with bit 31 clear. A normal frame without error writes 0x00000000.
- R7: A normal descriptor with byte count 0, or a setup descriptor whose count is not 192, writes back 0x00008000 (bit 15, error summary). It streams nothing and leaves the address table unchanged.
- R8: A setup descriptor (control bit 27) with count 192 streams nothing and writes back 0x7FFFFFFF. Buffer word w loads its low 16 bits into bits [16*(w%3)+15 : 16*(w%3)] of entry w/3, so address byte 0 sits in bits [7:0].
- R9: match_hit_o is high when match_addr_i equals any of the 16 entries. After reset every entry is all ones (broadcast).
- R10: With mode bit 7 set, any address with bit 0 set hits. With bit 7 clear this rule does not apply.
- R11: After a write-back the engine moves 16 bytes forward, or back to the ring base when control bit 25 (end of ring) is set. It then reads the next status word without a new poll.
- R12: Writing the ring base sets the current descriptor pointer to it once the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 base, 1 poll, 2 mode |
| reg_wdata_i | input | 32 | Register write data |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 32 | Byte address, word aligned |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request done; read data valid this cycle |
| mem_rdata_i | input | 32 | Read data |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_ready_i | input | 1 | MAC accepts the byte |
| tx_data_o | output | 8 | Stream byte |
| tx_first_o | output | 1 | First byte of a first segment |
| tx_last_o | output | 1 | Final byte of a last segment |
| match_addr_i | input | 48 | Destination address to look up, byte 0 in [7:0] |
| match_hit_o | output | 1 | Address accepted by the table or multicast mode |

## Verification
The bench models memory, the expected byte stream and the expected status write-backs as queues. It compares every accepted byte and every write on the clock where it happens. A wrong byte index or word step shows up on the first bad byte. A wrong ownership or wrap decision shows up as a missing or unexpected write-back, or as a wrong count of memory reads, within a few cycles of the poll. Table corruption is only visible through the lookup port, so the bench probes chosen entries, broadcast and unrelated addresses after each setup load.

// File: rtl/tx_desc_pkg.sv
package tx_desc_pkg;
  localparam int OWN_BIT  = 31;
  localparam int LS_BIT   = 30;
  localparam int FS_BIT   = 29;
  localparam int SET_BIT  = 27;
  localparam int EOR_BIT  = 25;
  localparam int TXEN_BIT = 13;
  localparam int PAM_BIT  = 7;

  localparam logic [31:0] STS_DONE     = 32'h0000_0000;
  localparam logic [31:0] STS_ERR      = 32'h0000_8000;
  localparam logic [31:0] STS_SETUP_OK = 32'h7FFF_FFFF;

  localparam logic [1:0] REG_BASE = 2'd0;
  localparam logic [1:0] REG_POLL = 2'd1;
  localparam logic [1:0] REG_MODE = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_STS, S_CTL, S_BUF, S_FETCH, S_SEND, S_WB
  } dma_state_e;
endpackage

// File: rtl/tx_desc_regs.sv
module tx_desc_regs
  import tx_desc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] base_o,
  output logic        base_ld_o,
  output logic        poll_o,
  output logic        tx_en_o,
  output logic        pam_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o    <= '0;
      base_ld_o <= 1'b0;
      poll_o    <= 1'b0;
      tx_en_o   <= 1'b0;
      pam_o     <= 1'b0;
    end else begin
      base_ld_o <= we_i && addr_i == REG_BASE;
      poll_o    <= we_i && addr_i == REG_POLL;
      if (we_i && addr_i == REG_BASE) base_o <= wdata_i;
      if (we_i && addr_i == REG_MODE) begin
        tx_en_o <= wdata_i[TXEN_BIT];
        pam_o   <= wdata_i[PAM_BIT];
      end
    end
  end
endmodule

// File: rtl/tx_desc_dma.sv
module tx_desc_dma
  import tx_desc_pkg::*;
#(
  parameter int ENTRIES    = 16,
  parameter int CNT_W      = 11,
  parameter int DESC_BYTES = 16,
  localparam int ENT_W       = $clog2(ENTRIES),
  localparam int SETUP_BYTES = ENTRIES * 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [31:0]      base_i,
  input  logic             base_ld_i,
  input  logic             poll_i,
  input  logic             tx_en_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [31:0]      mem_addr_o,
  output logic [31:0]      mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic [31:0]      mem_rdata_i,
  output logic             tx_valid_o,
  input  logic             tx_ready_i,
  output logic [7:0]       tx_data_o,
  output logic             tx_first_o,
  output logic             tx_last_o,
  output logic             tbl_we_o,
  output logic [ENT_W-1:0] tbl_ent_o,
  output logic [1:0]       tbl_part_o,
  output logic [15:0]      tbl_half_o
);
  dma_state_e       st_q;
  logic [31:0]      cur_q, buf_q, word_q;
  logic [CNT_W-1:0] cnt_q, idx_q, last_idx;
  logic             ls_q, fs_q, set_q, eor_q, err_q;
  logic             base_pend_q, poll_pend_q;
  logic [ENT_W-1:0] ent_q;
  logic [1:0]       part_q;
  logic             bad_len;

  assign last_idx = cnt_q - 1'b1;
  assign bad_len  = set_q ? (cnt_q != CNT_W'(SETUP_BYTES)) : (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE;
      cur_q <= '0; buf_q <= '0; word_q <= '0;
      cnt_q <= '0; idx_q <= '0;
      ls_q <= 1'b0; fs_q <= 1'b0; set_q <= 1'b0; eor_q <= 1'b0; err_q <= 1'b0;
      base_pend_q <= 1'b0; poll_pend_q <= 1'b0;
      ent_q <= '0; part_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: begin
          if (base_pend_q) begin
            cur_q       <= base_i;
            base_pend_q <= 1'b0;
          end else if (poll_pend_q) begin
            poll_pend_q <= 1'b0;
            st_q        <= S_STS;
          end
        end
        S_STS: if (mem_ack_i) st_q <= mem_rdata_i[OWN_BIT] ? S_CTL : S_IDLE;
        S_CTL: if (mem_ack_i) begin
          cnt_q <= mem_rdata_i[CNT_W-1:0];
          ls_q  <= mem_rdata_i[LS_BIT];
          fs_q  <= mem_rdata_i[FS_BIT];
          set_q <= mem_rdata_i[SET_BIT];
          eor_q <= mem_rdata_i[EOR_BIT];
          st_q  <= S_BUF;
        end
        S_BUF: if (mem_ack_i) begin
          buf_q  <= mem_rdata_i;
          idx_q  <= '0;
          ent_q  <= '0;
          part_q <= '0;
          err_q  <= bad_len;
          st_q   <= bad_len ? S_WB : S_FETCH;
        end
        S_FETCH: if (mem_ack_i) begin
          word_q <= mem_rdata_i;
          if (set_q) begin
            // setup words go to the table, never to the stream
            idx_q <= idx_q + CNT_W'(4);
            if (part_q == 2'd2) begin
              part_q <= '0;
              ent_q  <= ent_q + 1'b1;
            end else begin
              part_q <= part_q + 1'b1;
            end
            if (idx_q == CNT_W'(SETUP_BYTES - 4)) st_q <= S_WB;
          end else begin
            st_q <= S_SEND;
          end
        end
        S_SEND: if (tx_ready_i) begin
          if (idx_q == last_idx) st_q <= S_WB;
          else begin
            idx_q <= idx_q + 1'b1;
            if (idx_q[1:0] == 2'd3) st_q <= S_FETCH;
          end
        end
        S_WB: if (mem_ack_i) begin
          cur_q <= eor_q ? base_i : cur_q + 32'(DESC_BYTES);
          st_q  <= S_STS;
        end
        default: st_q <= S_IDLE;
      endcase
      if (base_ld_i) base_pend_q <= 1'b1;
      if (poll_i && tx_en_i) poll_pend_q <= 1'b1;
    end
  end

  always_comb begin
    mem_addr_o = cur_q;
    unique case (st_q)
      S_CTL:   mem_addr_o = cur_q + 32'd4;
      S_BUF:   mem_addr_o = cur_q + 32'd8;
      S_FETCH: mem_addr_o = buf_q + 32'({idx_q[CNT_W-1:2], 2'b00});
      default: mem_addr_o = cur_q;
    endcase
  end

  assign mem_req_o   = st_q inside {S_STS, S_CTL, S_BUF, S_FETCH, S_WB};
  assign mem_we_o    = st_q == S_WB;
  assign mem_wdata_o = err_q ? STS_ERR : (set_q ? STS_SETUP_OK : STS_DONE);

  assign tx_valid_o = st_q == S_SEND;
  assign tx_data_o  = word_q[{idx_q[1:0], 3'b000} +: 8];
  assign tx_first_o = tx_valid_o && fs_q && idx_q == '0;
  assign tx_last_o  = tx_valid_o && ls_q && idx_q == last_idx;

  assign tbl_we_o   = st_q == S_FETCH && mem_ack_i && set_q;
  assign tbl_ent_o  = ent_q;
  assign tbl_part_o = part_q;
  assign tbl_half_o = mem_rdata_i[15:0];

  // R4
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));
  // R3
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));
  // R6
  own_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> !mem_wdata_o[OWN_BIT]);
  // R8
  setup_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_we_o |-> !tx_valid_o);
endmodule

// File: rtl/tx_addr_filter.sv
module tx_addr_filter #(
  parameter int ENTRIES = 16,
  localparam int ENT_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [ENT_W-1:0] ent_i,
  input  logic [1:0]       part_i,
  input  logic [15:0]      half_i,
  input  logic             pam_i,
  input  logic [47:0]      addr_i,
  output logic             hit_o
);
  logic [47:0]        tbl_q [ENTRIES];
  logic [ENTRIES-1:0] hit_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < ENTRIES; e++) tbl_q[e] <= '1;
    end else if (we_i) begin
      unique case (part_i)
        2'd0:    tbl_q[ent_i][15:0]  <= half_i;
        2'd1:    tbl_q[ent_i][31:16] <= half_i;
        default: tbl_q[ent_i][47:32] <= half_i;
      endcase
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign hit_vec[e] = tbl_q[e] == addr_i;
  end

  assign hit_o = (|hit_vec) || (pam_i && addr_i[0]);

  // R8
  part_rng_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> part_i != 2'd3);
endmodule

// File: rtl/tx_desc_engine.sv
module tx_desc_engine #(
  parameter int ENTRIES = 16,
  parameter int CNT_W   = 11,
  localparam int ENT_W  = $clog2(ENTRIES)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  input  logic        mem_ack_i,
  input  logic [31:0] mem_rdata_i,
  output logic        tx_valid_o,
  input  logic        tx_ready_i,
  output logic [7:0]  tx_data_o,
  output logic        tx_first_o,
  output logic        tx_last_o,
  input  logic [47:0] match_addr_i,
  output logic        match_hit_o
);
  logic [31:0]      base;
  logic             base_ld, poll, tx_en, pam;
  logic             tbl_we;
  logic [ENT_W-1:0] tbl_ent;
  logic [1:0]       tbl_part;
  logic [15:0]      tbl_half;

  tx_desc_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .base_o(base), .base_ld_o(base_ld), .poll_o(poll), .tx_en_o(tx_en), .pam_o(pam)
  );

  tx_desc_dma #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_dma (
    .clk_i, .rst_ni,
    .base_i(base), .base_ld_i(base_ld), .poll_i(poll), .tx_en_i(tx_en),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i,
    .tx_valid_o, .tx_ready_i, .tx_data_o, .tx_first_o, .tx_last_o,
    .tbl_we_o(tbl_we), .tbl_ent_o(tbl_ent), .tbl_part_o(tbl_part), .tbl_half_o(tbl_half)
  );

  tx_addr_filter #(.ENTRIES(ENTRIES)) u_filter (
    .clk_i, .rst_ni,
    .we_i(tbl_we), .ent_i(tbl_ent), .part_i(tbl_part), .half_i(tbl_half),
    .pam_i(pam), .addr_i(match_addr_i), .hit_o(match_hit_o)
  );
endmodule

// File: tb/tb_tx_desc_engine.sv
`timescale 1ns/1ps
module tb_tx_desc_engine;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        tx_valid, tx_ready = 1'b1, tx_first, tx_last;
  logic [7:0]  tx_data;
  logic [47:0] match_addr = '0;
  logic        match_hit;

  int tests = 0, failed = 0, rd_cnt = 0, quiet = 0, cyc = 0;
  bit stall = 1'b0;
  logic [31:0] mem [0:1023];
  logic [9:0]  exp_b [$];
  logic [63:0] exp_w [$];

  localparam logic [31:0] C_LS = 32'h4000_0000, C_FS = 32'h2000_0000;
  localparam logic [31:0] C_SET = 32'h0800_0000, C_EOR = 32'h0200_0000;
  localparam logic [31:0] TXEN = 32'h2000, PAM = 32'h80;

  tx_desc_engine dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data),
    .tx_first_o(tx_first), .tx_last_o(tx_last),
    .match_addr_i(match_addr), .match_hit_o(match_hit)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: one-cycle acknowledge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[11:2]];
    end else mem_ack <= 1'b0;
  end

  // per-clock comparison against the reference queues
  always @(negedge clk) if (rst_n) begin
    tx_ready = stall ? (cyc % 3 != 0) : 1'b1;
    if (tx_valid && tx_ready) begin
      if (exp_b.size() == 0) chk(0, "R4 unexpected byte", {tx_first, tx_last, tx_data}, 0);
      else begin
        logic [9:0] e;
        e = exp_b.pop_front();
        chk({tx_first, tx_last, tx_data} == e, "R4 R5 stream byte", {tx_first, tx_last, tx_data}, e);
      end
    end
    if (mem_req && mem_we && !mem_ack) begin
      if (exp_w.size() == 0) chk(0, "R6 unexpected write", {mem_addr, mem_wdata}, 0);
      else begin
        logic [63:0] w;
        w = exp_w.pop_front();
        chk({mem_addr, mem_wdata} == w, "R6 status write-back", {mem_addr, mem_wdata}, w);
      end
    end
    if (mem_req && !mem_we && !mem_ack) rd_cnt++;
    if (mem_req || tx_valid) quiet = 0; else quiet++;
  end

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic wait_quiet();
    repeat (3) @(negedge clk);
    while (quiet < 16) @(negedge clk);
  endtask

  task automatic put_desc(input int a, input logic [31:0] ctl, input logic [31:0] b);
    mem[a >> 2] = 32'h8000_0000; mem[(a >> 2) + 1] = ctl;
    mem[(a >> 2) + 2] = b;       mem[(a >> 2) + 3] = '0;
  endtask

  task automatic put_buf(input int a, input int n, input int seed, input bit fs, input bit ls);
    for (int k = 0; k < n; k++) begin
      logic [7:0] v;
      v = 8'((seed + k * 7) & 255);
      mem[(a >> 2) + k / 4][8 * (k % 4) +: 8] = v;
      exp_b.push_back({fs && k == 0, ls && k == n - 1, v});
    end
  endtask

  function automatic logic [47:0] ent_addr(input int e);
    return {8'(e ^ 8'h5A), 8'h44, 8'h33, 8'(8'h10 + e), 8'(e), 8'h02};
  endfunction

  task automatic check_hit(input logic [47:0] a, input bit exp, input string tag);
    @(negedge clk); match_addr = a; #1;
    chk(match_hit == exp, tag, match_hit, exp);
  endtask

  task automatic queues_empty(input string tag);
    chk(exp_b.size() == 0 && exp_w.size() == 0, tag, exp_b.size() + exp_w.size(), 0);
  endtask

  initial begin
    int r0;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_valid && !mem_req, "R1 reset idle", {tx_valid, mem_req}, 0);
    check_hit(48'hFFFF_FFFF_FFFF, 1'b1, "R9 reset broadcast hit");
    check_hit(48'h0000_1234_5678, 1'b0, "R9 reset unicast miss");

    // R1: poll with transmission disabled
    reg_wr(2'd0, 32'h100);
    reg_wr(2'd1, 32'h1);
    repeat (20) @(negedge clk);
    chk(rd_cnt == 0, "R1 poll while disabled", rd_cnt, 0);

    // R2: descriptor not owned
    reg_wr(2'd2, TXEN);
    r0 = rd_cnt;
    reg_wr(2'd1, 32'h1);
    wait_quiet();
    chk(rd_cnt - r0 == 1, "R2 single status read", rd_cnt - r0, 1);
    chk(mem[32'h100 >> 2] == 0, "R2 status untouched", mem[32'h100 >> 2], 0);

    // R3 R4 R5 R6: single-segment 7-byte frame
    put_desc(32'h100, C_FS | C_LS | 32'd7, 32'h400);
    mem[32'h110 >> 2] = '0;
    put_buf(32'h400, 7, 8'h21, 1'b1, 1'b1);
    exp_w.push_back({32'h100, 32'h0});
    r0 = rd_cnt;
    reg_wr(2'd1, 32'h1);
    wait_quiet();
    queues_empty("R4 R6 normal frame complete");
    chk(rd_cnt - r0 == 6, "R3 read count", rd_cnt - r0, 6);

    // R5 R11 R12: two segments, stalled MAC, wrap at end of ring
    reg_wr(2'd0, 32'h100);
    put_desc(32'h100, C_FS | 32'd5, 32'h400);
    put_desc(32'h110, C_LS | C_EOR | 32'd4, 32'h500);
    put_buf(32'h400, 5, 8'h11, 1'b1, 1'b0);
    put_buf(32'h500, 4, 8'h80, 1'b0, 1'b1);
    exp_w.push_back({32'h100, 32'h0});
    exp_w.push_back({32'h110, 32'h0});
    stall = 1'b1;
    r0 = rd_cnt;
    reg_wr(2'd1, 32'h1);
    wait_quiet();
    stall = 1'b0;
    queues_empty("R5 R12 two-segment frame");
    chk(rd_cnt - r0 == 10, "R11 wrap rereads ring base", rd_cnt - r0, 10);

    // R7: zero byte count
    reg_wr(2'd0, 32'h100);
    put_desc(32'h100, C_FS | C_LS | C_EOR, 32'h400);
    exp_w.push_back({32'h100, 32'h8000});
    reg_wr(2'd1, 32'h1);
    wait_quiet();
    queues_empty("R7 zero count error");
    chk(mem[32'h100 >> 2] == 32'h8000, "R7 error status", mem[32'h100 >> 2], 32'h8000);

    // R8: setup frame
    reg_wr(2'd0, 32'h100);
    put_desc(32'h100, C_SET | C_EOR | 32'd192, 32'h600);
    for (int w = 0; w < 48; w++) begin
      logic [47:0] a;
      a = ent_addr(w / 3);
      mem[(32'h600 >> 2) + w] = {16'hFFFF, a[16 * (w % 3) +: 16]};
    end
    exp_w.push_back({32'h100, 32'h7FFF_FFFF});
    reg_wr(2'd1, 32'h1);
    wait_quiet();
    queues_empty("R8 setup load, no bytes streamed");
    check_hit(ent_addr(0), 1'b1, "R8 entry 0 hit");
    check_hit(ent_addr(5), 1'b1, "R8 entry 5 hit");
    check_hit(ent_addr(15), 1'b1, "R9 entry 15 hit");
    check_hit(48'hFFFF_FFFF_FFFF, 1'b0, "R9 broadcast replaced");
    check_hit(48'h0000_1234_5678, 1'b0, "R9 unknown miss");

    // R7: setup with wrong length leaves table alone
    for (int w = 0; w < 48; w++) mem[(32'h600 >> 2) + w] = '0;
    put_desc(32'h100, C_SET | C_EOR | 32'd100, 32'h600);
    exp_w.push_back({32'h100, 32'h8000});
    reg_wr(2'd1, 32'h1);
    wait_quiet();
    queues_empty("R7 bad setup length");
    check_hit(ent_addr(3), 1'b1, "R7 table kept");

    // R10: pass-all-multicast
    reg_wr(2'd2, TXEN | PAM);
    check_hit(48'hABCD_EF12_3401, 1'b1, "R10 multicast hit");
    check_hit(48'hABCD_EF12_3402, 1'b0, "R10 unicast miss");
    reg_wr(2'd2, TXEN);
    check_hit(48'hABCD_EF12_3401, 1'b0, "R10 mode off miss");

    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; failed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule